// File: doc/BRIEF.md
# Configuration Transaction Engine

This block lets software reach a small table of board configuration items through three 32-bit registers. Software first loads a data register. It then writes a control word that carries a launch bit, a direction bit and five addressing fields. In the same clock edge as that control write, the engine decodes the fields and checks that the target exists. It then performs the access. A read of a clock entry or a voltage sensor puts its result into the data register. A write takes its value from the data register as it stood before the launch.

Every launch leaves a two-bit outcome in a status register: done, and done-with-error. That outcome holds until the next launch or until software writes the status register directly. Two targets produce events instead of storage updates: a power-off request and a restart request. Each appears as a one-cycle pulse on a dedicated output. There is no busy phase. All effects of a launch are visible in the cycle after the control write.

The register port is a plain write strobe with a shared byte address. Read data comes out combinationally from that address. It has no valid/ready handshake and no back-pressure, because every access completes in one cycle. The event outputs are plain level pins, high for exactly one cycle.

Top module: `cfg_xact_top`

## Requirements
- R1: After reset, the data, control and status registers read 0, both event outputs are low, and the clock table holds its reset values. The six motherboard entries are 50000000, 23750000 and 24000000 (entries 2 to 5). Each daughterboard entry holds its own reset parameter.
- R2: The control word is at byte offset 0xA4. Its fields are: bit 31 launch, bit 30 direction (1 = write, 0 = read), bits 29:26 controller index, bits 25:20 function, bits 17:16 site, bits 15:12 stack position, bits 11:0 device. Bits 31 and 19:18 are never stored and always read back 0. All other bits read back as written.
- R3: A control write with bit 31 set launches an operation. The status register (offset 0xA8) then becomes 1 on success or 3 on error, whatever it held before. A control write with bit 31 clear changes neither status nor data.
- R4: An operation fails with error if the controller index is nonzero, if the stack position is nonzero, or if the site is 2 or 3.
- R5: A read with function 1 returns a clock entry into the data register (offset 0xA0). Site 0 covers devices 0 to 5 of the motherboard table. Site 1 covers devices below the daughterboard clock count. Any other device is an error.
- R6: A write with function 1 to a valid entry stores the data register value into that entry. A later read returns the stored value.
- R7: A read with function 2 returns 3300000 for site 0, device 0. For site 1 it returns the per-sensor parameter for devices below the sensor count. Every other function 2 read, and every function 2 write, is an error.
- R8: Writes with function 7 or function 11 to site 0, device 0 succeed and change no state. The same functions fail when read, or when aimed at any other site or device. Any function other than 1, 2, 7, 8, 9 and 11 is an error.
- R9: A successful write with function 8 to site 0, device 0 raises the power-off output for exactly one cycle. Function 9 does the same on the restart output. No other operation raises either output, and the two are never high together.
- R10: A direct write to the status register keeps only bits 1:0 of the written value.
- R11: A failed operation, or any successful write, leaves the data register unchanged.
- R12: Addresses other than 0xA0, 0xA4 and 0xA8 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| poweroff_pulse | output | 1 | One-cycle power-off request |
| restart_pulse | output | 1 | One-cycle restart request |

## Verification
The bench sweeps every function from 0 to 12, every site, devices 0 to 7 and both directions. It runs a read pass, then a write pass, then a second read pass. Expected status, data and event values come from a table model kept in the bench.

The sweep targets the edges of the device index: device 5 against 6 at the motherboard, and the clock and sensor counts at the daughterboard. An off-by-one bound would return a stale value, or report success where an error is due.

Separate cases cover the other corners:
- A launch with all ones checks that bit 31 and bits 19:18 are dropped. A design that stored them would read back a set launch bit.
- A stale error must be overwritten by the next good launch. A design that ORed status would keep the error.
- The bench writes a data pattern before each failed read, then confirms that pattern is still there. This catches a design that loads the data register on failure.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

  localparam int unsigned WORD_W = 32;

  // Register byte offsets.
  localparam logic [7:0] OFS_DATA = 8'hA0;
  localparam logic [7:0] OFS_CTRL = 8'hA4;
  localparam logic [7:0] OFS_STAT = 8'hA8;

  // Control word layout, most significant field first.
  typedef struct packed {
    logic        launch;
    logic        is_write;
    logic [3:0]  ctl_idx;
    logic [5:0]  func;
    logic [1:0]  spare;
    logic [1:0]  site;
    logic [3:0]  stack_pos;
    logic [11:0] dev;
  } cfg_word_t;

  // Bits that are kept when the control word is stored.
  localparam logic [31:0] CTRL_KEEP = 32'h7FF3_FFFF;

  // Function codes.
  localparam logic [5:0] FN_CLOCK   = 6'd1;
  localparam logic [5:0] FN_VOLTAGE = 6'd2;
  localparam logic [5:0] FN_VIDMUX  = 6'd7;
  localparam logic [5:0] FN_OFF     = 6'd8;
  localparam logic [5:0] FN_RESTART = 6'd9;
  localparam logic [5:0] FN_DISPLAY = 6'd11;

  localparam logic [1:0] SITE_MAIN = 2'd0;
  localparam logic [1:0] SITE_DAUG = 2'd1;

  localparam int unsigned MB_CLOCKS = 6;
  localparam logic [31:0] MB_VIO_UV = 32'd3300000;

  // Motherboard clock reset table, entry 0 in the low word.
  localparam logic [MB_CLOCKS*32-1:0] MB_CLK_RST = {
    32'd24000000, 32'd24000000, 32'd24000000,
    32'd24000000, 32'd23750000, 32'd50000000
  };

endpackage

// File: rtl/cfg_clk_bank.sv
module cfg_clk_bank #(
  parameter int unsigned N     = 2,
  parameter int unsigned IDX_W = 1,
  parameter logic [N*32-1:0] RST = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata
);

  logic [31:0] entry [N];

  for (genvar g = 0; g < N; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        entry[g] <= RST[g*32 +: 32];
      else if (we && (32'(idx) == g))
        entry[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N; i++)
      if (32'(idx) == i) rdata = entry[i];
  end

endmodule

// File: rtl/cfg_decode.sv
module cfg_decode
  import cfg_pkg::*;
#(
  parameter int unsigned DB_CLOCKS  = 2,
  parameter int unsigned DB_SENSORS = 2,
  parameter logic [DB_SENSORS*32-1:0] DB_VOLT = '0
) (
  input  cfg_word_t   word,
  input  logic [31:0] mb_clk,
  input  logic [31:0] db_clk,
  output logic        ok,
  output logic [31:0] rd_val,
  output logic        mb_we,
  output logic        db_we,
  output logic        off_req,
  output logic        restart_req
);

  logic base_ok, at_main, at_daug, main_dev0;
  logic [31:0] sensor_val;

  assign base_ok   = (word.ctl_idx == '0) && (word.stack_pos == '0) &&
                     (word.site == SITE_MAIN || word.site == SITE_DAUG);
  assign at_main   = base_ok && (word.site == SITE_MAIN);
  assign at_daug   = base_ok && (word.site == SITE_DAUG);
  assign main_dev0 = at_main && (word.dev == '0);

  always_comb begin
    sensor_val = '0;
    for (int i = 0; i < DB_SENSORS; i++)
      if (32'(word.dev) == i) sensor_val = DB_VOLT[i*32 +: 32];
  end

  always_comb begin
    ok = 1'b0; rd_val = '0; mb_we = 1'b0; db_we = 1'b0;
    off_req = 1'b0; restart_req = 1'b0;
    unique case (word.func)
      FN_CLOCK: begin
        if (at_main && 32'(word.dev) < MB_CLOCKS) begin
          ok = 1'b1; rd_val = mb_clk; mb_we = word.is_write;
        end else if (at_daug && 32'(word.dev) < DB_CLOCKS) begin
          ok = 1'b1; rd_val = db_clk; db_we = word.is_write;
        end
      end
      FN_VOLTAGE: begin
        if (!word.is_write) begin
          if (main_dev0) begin
            ok = 1'b1; rd_val = MB_VIO_UV;
          end else if (at_daug && 32'(word.dev) < DB_SENSORS) begin
            ok = 1'b1; rd_val = sensor_val;
          end
        end
      end
      FN_VIDMUX, FN_DISPLAY: ok = word.is_write && main_dev0;
      FN_OFF: begin
        ok = word.is_write && main_dev0; off_req = ok;
      end
      FN_RESTART: begin
        ok = word.is_write && main_dev0; restart_req = ok;
      end
      default: ok = 1'b0;
    endcase
  end

endmodule

// File: rtl/cfg_xact_top.sv
module cfg_xact_top
  import cfg_pkg::*;
#(
  parameter int unsigned DB_CLOCKS  = 2,
  parameter logic [DB_CLOCKS*32-1:0] DB_CLK_RST = {32'd33000000, 32'd66000000},
  parameter int unsigned DB_SENSORS = 2,
  parameter logic [DB_SENSORS*32-1:0] DB_VOLT = {32'd1800000, 32'd1000000}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        poweroff_pulse,
  output logic        restart_pulse
);

  localparam int unsigned MB_IW = $clog2(MB_CLOCKS);
  localparam int unsigned DB_IW = (DB_CLOCKS > 1) ? $clog2(DB_CLOCKS) : 1;

  cfg_word_t   cw;
  logic        wr_data, wr_ctrl, wr_stat, go;
  logic [31:0] data_q, ctrl_q;
  logic [1:0]  stat_q;
  logic        off_q, rst_q;

  logic        d_ok, d_mb_we, d_db_we, d_off, d_restart;
  logic [31:0] d_rd, mb_rd, db_rd;

  assign cw      = cfg_word_t'(bus_wdata);
  assign wr_data = bus_wr && (bus_addr == OFS_DATA);
  assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
  assign wr_stat = bus_wr && (bus_addr == OFS_STAT);
  assign go      = wr_ctrl && cw.launch;

  cfg_clk_bank #(.N(MB_CLOCKS), .IDX_W(MB_IW), .RST(MB_CLK_RST)) u_mb (
    .clk(clk), .rst_n(rst_n), .we(go && d_mb_we),
    .idx(cw.dev[MB_IW-1:0]), .wdata(data_q), .rdata(mb_rd)
  );

  cfg_clk_bank #(.N(DB_CLOCKS), .IDX_W(DB_IW), .RST(DB_CLK_RST)) u_db (
    .clk(clk), .rst_n(rst_n), .we(go && d_db_we),
    .idx(cw.dev[DB_IW-1:0]), .wdata(data_q), .rdata(db_rd)
  );

  cfg_decode #(.DB_CLOCKS(DB_CLOCKS), .DB_SENSORS(DB_SENSORS), .DB_VOLT(DB_VOLT)) u_dec (
    .word(cw), .mb_clk(mb_rd), .db_clk(db_rd), .ok(d_ok), .rd_val(d_rd),
    .mb_we(d_mb_we), .db_we(d_db_we), .off_req(d_off), .restart_req(d_restart)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0; ctrl_q <= '0; stat_q <= '0; off_q <= 1'b0; rst_q <= 1'b0;
    end else begin
      off_q <= go && d_off;
      rst_q <= go && d_restart;
      if (wr_ctrl) ctrl_q <= bus_wdata & CTRL_KEEP;
      if (go) begin
        stat_q <= {~d_ok, 1'b1};
        if (d_ok && !cw.is_write) data_q <= d_rd;
      end else begin
        if (wr_stat) stat_q <= bus_wdata[1:0];
        if (wr_data) data_q <= bus_wdata;
      end
    end
  end

  always_comb begin
    unique case (bus_addr)
      OFS_DATA: bus_rdata = data_q;
      OFS_CTRL: bus_rdata = ctrl_q;
      OFS_STAT: bus_rdata = {30'd0, stat_q};
      default:  bus_rdata = '0;
    endcase
  end

  assign poweroff_pulse = off_q;
  assign restart_pulse  = rst_q;

  AST_CTRL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (bus_rdata[31] == 1'b0 || bus_addr != OFS_CTRL) && ctrl_q[31] == 1'b0 && ctrl_q[19:18] == 2'b00); // R2
  AST_LAUNCH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> stat_q[0]); // R3
  AST_BAD_CTL_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (go && (cw.ctl_idx != '0 || cw.stack_pos != '0 || cw.site[1])) |=> (stat_q == 2'b11)); // R4
  AST_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (poweroff_pulse || restart_pulse) |=> !(poweroff_pulse || restart_pulse)); // R9
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({poweroff_pulse, restart_pulse})); // R9
  AST_STAT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> stat_q == $past(bus_wdata[1:0])); // R10
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_data || go) |=> $stable(data_q)); // R11

endmodule

// File: tb/sim_cfg_xact_top.sv
`timescale 1ns/1ps
module sim_cfg_xact_top;

  localparam int DBC = 2;
  localparam int DBS = 3;
  localparam logic [DBC*32-1:0] DB_CR = {32'd12345678, 32'd87654321};
  localparam logic [DBS*32-1:0] DB_V  = {32'd900000, 32'd1200000, 32'd1500000};

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic poweroff_pulse, restart_pulse;

  always #4 clk = ~clk;

  cfg_xact_top #(.DB_CLOCKS(DBC), .DB_CLK_RST(DB_CR), .DB_SENSORS(DBS), .DB_VOLT(DB_V)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .poweroff_pulse(poweroff_pulse), .restart_pulse(restart_pulse)
  );

  int n_chk = 0, n_bad = 0;
  logic [31:0] mb [6];
  logic [31:0] db [DBC];

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Drive a write in the low phase; return at the following negedge.
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  function automatic logic [31:0] cword(input int w, input int ci, input int fn,
                                        input int site, input int pos, input int dev);
    return {1'b1, 1'(w), 4'(ci), 6'(fn), 2'b00, 2'(site), 4'(pos), 12'(dev)};
  endfunction

  // Model: ok, read value, event kind (1 = off, 2 = restart), applies writes.
  task automatic model(input int w, input int fn, input int site, input int dev,
                       input logic [31:0] dval, output bit ok, output logic [31:0] rv,
                       output int ev);
    ok = 0; rv = '0; ev = 0;
    if (site > 1) return;
    if (fn == 1) begin
      if (site == 0 && dev < 6) begin ok = 1; rv = mb[dev]; if (w) mb[dev] = dval; end
      else if (site == 1 && dev < DBC) begin ok = 1; rv = db[dev]; if (w) db[dev] = dval; end
    end else if (fn == 2) begin
      if (!w && site == 0 && dev == 0) begin ok = 1; rv = 32'd3300000; end
      else if (!w && site == 1 && dev < DBS) begin ok = 1; rv = DB_V[dev*32 +: 32]; end
    end else if (fn == 7 || fn == 11 || fn == 8 || fn == 9) begin
      ok = (w == 1) && site == 0 && dev == 0;
      if (ok && fn == 8) ev = 1;
      if (ok && fn == 9) ev = 2;
    end
  endtask

  task automatic sweep(input int w, input int pass);
    for (int fn = 0; fn <= 12; fn++)
      for (int site = 0; site < 4; site++)
        for (int dev = 0; dev < 8; dev++) begin
          bit ok; logic [31:0] rv, got, pat; int ev;
          pat = 32'hA500_0000 ^ (pass << 20) ^ (fn << 8) ^ (site << 4) ^ dev;
          wr(8'hA0, pat);
          model(w, fn, site, dev, pat, ok, rv, ev);
          wr(8'hA4, cword(w, 0, fn, site, 0, dev));
          chk("R9 poweroff", {31'd0, poweroff_pulse}, {31'd0, ev == 1});
          chk("R9 restart", {31'd0, restart_pulse}, {31'd0, ev == 2});
          rd(8'hA8, got);
          chk(site > 1 ? "R4 status" : (fn == 2 ? "R7 status" : (fn == 1 ? "R5 status" : "R8 status")),
              got, ok ? 32'd1 : 32'd3);
          rd(8'hA0, got);
          chk((ok && !w) ? (fn == 1 ? (pass == 2 ? "R6 data" : "R5 data") : "R7 data") : "R11 data",
              got, (ok && !w) ? rv : pat);
          @(negedge clk);
          chk("R9 pulse width", {30'd0, poweroff_pulse, restart_pulse}, 32'd0);
        end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    logic [31:0] got, pat;
    for (int i = 0; i < 6; i++) mb[i] = (i == 0) ? 32'd50000000 : (i == 1 ? 32'd23750000 : 32'd24000000);
    for (int i = 0; i < DBC; i++) db[i] = DB_CR[i*32 +: 32];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'hA0, got); chk("R1 data reset", got, 0);
    rd(8'hA4, got); chk("R1 ctrl reset", got, 0);
    rd(8'hA8, got); chk("R1 status reset", got, 0);
    chk("R1 events reset", {30'd0, poweroff_pulse, restart_pulse}, 0);

    sweep(0, 0);   // R1 R5 R7: reset values and reads
    sweep(1, 1);   // R6 R8 R9: writes
    sweep(0, 2);   // R6: readback of written entries

    // R2: launch with every bit set; masked readback, controller index error.
    wr(8'hA0, 32'h1111_2222);
    wr(8'hA4, 32'hFFFF_FFFF);
    rd(8'hA4, got); chk("R2 ctrl mask", got, 32'h7FF3_FFFF);
    rd(8'hA8, got); chk("R4 status all ones", got, 3);
    // R4: nonzero controller index, nonzero position on otherwise valid read.
    wr(8'hA4, cword(0, 1, 1, 0, 0, 0));
    rd(8'hA8, got); chk("R4 ctl idx", got, 3);
    rd(8'hA0, got); chk("R11 data after ctl err", got, 32'h1111_2222);
    wr(8'hA4, cword(0, 0, 1, 0, 3, 0));
    rd(8'hA8, got); chk("R4 position", got, 3);
    // R3: good launch overwrites stale error.
    wr(8'hA4, cword(0, 0, 2, 0, 0, 0));
    rd(8'hA8, got); chk("R3 overwrite", got, 1);
    rd(8'hA0, got); chk("R7 mb voltage", got, 32'd3300000);
    // R3: no launch bit: status and data untouched.
    wr(8'hA8, 32'h2);
    wr(8'hA4, 32'h0010_0000);
    rd(8'hA8, got); chk("R3 no launch status", got, 2);
    rd(8'hA4, got); chk("R2 stored no launch", got, 32'h0010_0000);
    rd(8'hA0, got); chk("R3 no launch data", got, 32'd3300000);
    // R10
    wr(8'hA8, 32'hFFFF_FFFC); rd(8'hA8, got); chk("R10 low bits zero", got, 0);
    wr(8'hA8, 32'h0000_0007); rd(8'hA8, got); chk("R10 low bits kept", got, 3);
    // R12
    pat = 32'hDEAD_BEEF;
    wr(8'hA0, pat);
    wr(8'hAC, 32'h1234_5678); rd(8'hAC, got); chk("R12 unmapped read", got, 0);
    wr(8'h00, 32'h8010_0000); rd(8'h00, got); chk("R12 unmapped low", got, 0);
    rd(8'hA0, got); chk("R12 data kept", got, pat);
    rd(8'hA8, got); chk("R12 status kept", got, 3);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule